// File: doc/BRIEF.md
# UART receive FIFO with trigger interrupts

This block is the receive-side character store of a UART. Characters come in either from the serial receiver or, when loopback is on, from the transmit write path. They are held in order and handed out one per read request on a registered data port. The block keeps a live fill count and raises full and empty flags. It raises a sticky overrun flag when a character has to be thrown away. It also drives two level-style interrupt requests: one tied to a programmable fill threshold, and one that stays high while any character is waiting.

The store runs in one of two modes. With buffering enabled it holds up to 2^AW characters (16 by default). With buffering disabled it acts as a single holding register. Every change of the mode input empties the store and applies the new capacity. The threshold is picked by a 3-bit code as a fraction of the capacity, in eighths. The threshold interrupt fires only when the count moves upward across that threshold.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset the block is in single-slot mode with count 0, `empty`=1 and all other outputs 0. With `fifo_en`=1 the capacity is DEPTH=2^AW entries. With `fifo_en`=0 the capacity is 1 entry.
- R2: In a cycle where `fifo_en` differs from the current mode, the store is emptied and the new mode is taken. Any arrival or pop in that cycle is discarded and counts neither as data nor as overrun. Both interrupts clear, and from the next cycle `count`=0 and `empty`=1.
- R3: In buffered mode the threshold from `lvl_sel` is: 0→DEPTH/8, 1→DEPTH/4, 2→DEPTH/2, 3→3·DEPTH/4, 4→7·DEPTH/8, and 5, 6, 7→DEPTH. With the default depth these are 2, 4, 8, 12, 14 and 16.
- R4: In single-slot mode the threshold is 1, whatever `lvl_sel` holds.
- R5: `irq_level` rises when an arrival without a pop moves the count from below the threshold to at or above it. It rises one cycle after that arrival.
- R6: `irq_level` falls when a pop without an arrival leaves the count below the threshold in force at that moment. A change of `lvl_sel` alone does not move it.
- R7: `irq_data` is set by every arrival that is not discarded, including one dropped on overflow. It is cleared by a pop that empties the store. It therefore always equals the inverse of `empty`.
- R8: An arrival when the count equals the capacity and no pop is accepted is dropped and sets `overrun`. `overrun` stays set until `ovr_clr` is high. If a drop and `ovr_clr` coincide, the flag stays set.
- R9: `full` is 1 exactly when the count equals the capacity of the current mode. `empty` is 1 exactly when the count is 0. The two are never 1 together.
- R10: With `loop_en`=1 the arrival is `tx_valid`/`tx_data` and the line inputs are ignored. With `loop_en`=0 the arrival is `line_valid`/`line_data` and the transmit inputs are ignored.
- R11: An arrival and a pop in the same cycle are both accepted when the store holds at least one character, even when it is full. The count is then unchanged, no overrun is set and the popped value is the oldest character.
- R12: A pop while the store is empty puts 0 on `rd_data` one cycle later and changes neither the count nor the interrupts.
- R13: Characters leave in arrival order. `rd_data` shows the popped character from the clock edge that accepts the pop, and holds it until the next pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: buffered mode, 0: single-slot mode |
| lvl_sel | input | 3 | Threshold code |
| loop_en | input | 1 | Take arrivals from the transmit path |
| line_valid | input | 1 | Character from the serial receiver is present |
| line_data | input | DW | Character from the serial receiver |
| tx_valid | input | 1 | Transmit write strobe |
| tx_data | input | DW | Transmit write character |
| pop | input | 1 | Read one character |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | DW | Last popped character (0 after an empty pop) |
| count | output | AW+1 | Number of stored characters |
| full | output | 1 | Store is at capacity |
| empty | output | 1 | Store holds nothing |
| irq_level | output | 1 | Threshold interrupt request |
| irq_data | output | 1 | Data-present interrupt request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults, DW=8 and AW=4, so the capacity is 16. Every threshold code then lands on a distinct whole count (2, 4, 8, 12, 14, 16), and the bench can show the exact count at which each one rises. This depth also lets the bench fill the store completely and push past it in a few dozen cycles. That covers the full-store push-and-pop case, overflow, and the code whose threshold equals the capacity. The single-slot mode and the flush on a mode change are reached in both directions from the same build.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Fill level at which the threshold interrupt rises.
  function automatic int unsigned rxf_threshold(input logic [2:0] sel,
                                                input logic       multi,
                                                input int unsigned depth);
    if (!multi) return 1;
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          multi,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data
);
  localparam int ENTRIES = 2 ** AW;

  logic [DW-1:0] mem [ENTRIES];
  logic [AW-1:0] wp, rp;

  // Array write port, no reset so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  // Registered read port, read-before-write on a shared address.
  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_en)  rd_data <= mem[rp];
    else if (rd_req) rd_data <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en) wp <= multi ? wp + 1'b1 : '0;
      if (rd_en) rp <= multi ? rp + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          multi,
  input  logic          next_multi,
  input  logic [2:0]    lvl_sel,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drop,
  output logic [AW:0]   thr,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty
);
  localparam int          CW    = AW + 1;
  localparam int unsigned DEPTH = 2 ** AW;

  logic [CW-1:0] cap, cap_next, cnt_nx;
  logic          at_cap;

  always_comb begin
    cap      = multi      ? CW'(DEPTH) : CW'(1);
    cap_next = next_multi ? CW'(DEPTH) : CW'(1);
    thr      = CW'(rxf_pkg::rxf_threshold(lvl_sel, multi, DEPTH));
    at_cap   = (count == cap);
    pop_ok   = pop_req && (count != '0) && !flush;
    push_ok  = push_req && !flush && (!at_cap || pop_ok);
    drop     = push_req && !flush && !push_ok;
    if (flush) cnt_nx = '0;
    else       cnt_nx = count + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      count <= cnt_nx;
      full  <= (cnt_nx == cap_next);
      empty <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        arrive,
  input  logic        push_ok,
  input  logic        pop_ok,
  input  logic        drop,
  input  logic        ovr_clr,
  input  logic [AW:0] count,
  input  logic [AW:0] thr,
  output logic        irq_level,
  output logic        irq_data,
  output logic        overrun
);
  localparam int CW = AW + 1;

  logic [CW-1:0] cnt_up, cnt_dn;
  logic          only_push, only_pop;

  always_comb begin
    cnt_up    = count + CW'(1);
    cnt_dn    = count - CW'(1);
    only_push = push_ok && !pop_ok;
    only_pop  = pop_ok && !push_ok;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      irq_level <= 1'b0;
      irq_data  <= 1'b0;
    end else begin
      if (only_push && (count < thr) && (cnt_up >= thr)) irq_level <= 1'b1;
      else if (only_pop && (cnt_dn < thr))               irq_level <= 1'b0;

      if (arrive)                               irq_data <= 1'b1;
      else if (only_pop && (count == CW'(1)))   irq_data <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          overrun <= 1'b0;
    else if (drop)    overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [2:0]    lvl_sel,
  input  logic          loop_en,
  input  logic          line_valid,
  input  logic [DW-1:0] line_data,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          pop,
  input  logic          ovr_clr,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty,
  output logic          irq_level,
  output logic          irq_data,
  output logic          overrun
);
  logic          mode_q;
  logic          flush;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          push_ok, pop_ok, drop;
  logic [AW:0]   thr;

  always_comb begin
    flush     = (fifo_en != mode_q);
    src_valid = loop_en ? tx_valid : line_valid;
    src_data  = loop_en ? tx_data  : line_data;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= fifo_en;
  end

  rxf_level #(.AW(AW)) level_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .multi      (mode_q),
    .next_multi (fifo_en),
    .lvl_sel    (lvl_sel),
    .push_req   (src_valid),
    .pop_req    (pop),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .drop       (drop),
    .thr        (thr),
    .count      (count),
    .full       (full),
    .empty      (empty)
  );

  rxf_store #(.DW(DW), .AW(AW)) store_i (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .multi   (mode_q),
    .wr_en   (push_ok),
    .wr_data (src_data),
    .rd_en   (pop_ok),
    .rd_req  (pop && !flush),
    .rd_data (rd_data)
  );

  rxf_irq #(.AW(AW)) irq_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .arrive    (src_valid && !flush),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .drop      (drop),
    .ovr_clr   (ovr_clr),
    .count     (count),
    .thr       (thr),
    .irq_level (irq_level),
    .irq_data  (irq_data),
    .overrun   (overrun)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          mode_cur,
  input logic          pop,
  input logic          ovr_clr,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   count,
  input logic          full,
  input logic          empty,
  input logic          irq_data,
  input logic          overrun
);
  localparam int DEPTH = 2 ** AW;

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (mode_cur ? (AW+1)'(DEPTH) : (AW+1)'(1)));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R7
  data_irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq_data == !empty);

  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en != mode_cur) |=> (empty && !irq_data));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);

  // R12
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && (fifo_en == mode_cur)) |=> (rd_data == '0));
endmodule

bind rx_fifo_irq rxf_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .fifo_en  (fifo_en),
  .mode_cur (mode_q),
  .pop      (pop),
  .ovr_clr  (ovr_clr),
  .rd_data  (rd_data),
  .count    (count),
  .full     (full),
  .empty    (empty),
  .irq_data (irq_data),
  .overrun  (overrun)
);

// File: tb/rx_fifo_irq_tb_top.sv
`timescale 1ns/1ps
module rx_fifo_irq_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_en = 1'b0;
  logic [2:0]    lvl_sel = 3'd0;
  logic          loop_en = 1'b0;
  logic          line_valid = 1'b0;
  logic [DW-1:0] line_data = '0;
  logic          tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic          pop = 1'b0;
  logic          ovr_clr = 1'b0;
  logic [DW-1:0] rd_data;
  logic [AW:0]   count;
  logic          full, empty, irq_level, irq_data, overrun;

  always #2.5 clk = ~clk;

  rx_fifo_irq #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .lvl_sel(lvl_sel),
    .loop_en(loop_en), .line_valid(line_valid), .line_data(line_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .pop(pop), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .count(count), .full(full), .empty(empty),
    .irq_level(irq_level), .irq_data(irq_data), .overrun(overrun)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic ck(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int  mq[$];
  bit  m_mode, m_lvl, m_dat, m_ovr;
  int  m_rd;

  function automatic int exp_thr(input int sel, input bit multi);
    if (!multi) return 1;
    case (sel)
      0: return DEPTH / 8;
      1: return DEPTH / 4;
      2: return DEPTH / 2;
      3: return DEPTH * 3 / 4;
      4: return DEPTH * 7 / 8;
      default: return DEPTH;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_mode = 0; m_lvl = 0; m_dat = 0; m_ovr = 0; m_rd = 0;
    end else begin
      bit sv; int sd; int oldn; int cap; int th; bit pok; bit wok;
      if (ovr_clr) m_ovr = 0;
      if (fifo_en != m_mode) begin
        mq.delete(); m_mode = fifo_en; m_lvl = 0; m_dat = 0;
      end else begin
        sv   = loop_en ? tx_valid : line_valid;
        sd   = loop_en ? int'(tx_data) : int'(line_data);
        oldn = mq.size();
        cap  = m_mode ? DEPTH : 1;
        th   = exp_thr(int'(lvl_sel), m_mode);
        pok  = pop && oldn > 0;
        wok  = sv && (oldn < cap || pok);
        if (pok) m_rd = mq.pop_front();
        else if (pop) m_rd = 0;
        if (wok) mq.push_back(sd);
        if (sv && !wok) m_ovr = 1;
        if (wok && !pok && oldn < th && mq.size() >= th) m_lvl = 1;
        if (pok && !wok && mq.size() < th) m_lvl = 0;
        if (sv) m_dat = 1;
        if (pok && !wok && mq.size() == 0) m_dat = 0;
      end
    end
  end

  task automatic compare_all();
    ck("R13", "count", int'(count), mq.size());
    ck("R9", "full", int'(full), int'(mq.size() == (m_mode ? DEPTH : 1)));
    ck("R9", "empty", int'(empty), int'(mq.size() == 0));
    ck("R5", "irq_level", int'(irq_level), int'(m_lvl));
    ck("R7", "irq_data", int'(irq_data), int'(m_dat));
    ck("R8", "overrun", int'(overrun), int'(m_ovr));
    ck("R13", "rd_data", int'(rd_data), m_rd);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    line_valid = 0; tx_valid = 0; pop = 0; ovr_clr = 0;
  endtask

  task automatic push_line(input int d);
    line_valid = 1; line_data = DW'(d); cyc(); idle();
  endtask

  task automatic pop1();
    pop = 1; cyc(); idle();
  endtask

  task automatic set_mode(input bit m);
    fifo_en = m; cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rise;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    ck("R1", "reset count", int'(count), 0);
    ck("R1", "reset empty", int'(empty), 1);
    ck("R1", "reset irq", int'(irq_level | irq_data | overrun | full), 0);

    // Single-slot mode: capacity 1, threshold 1
    lvl_sel = 3'd3;
    push_line(8'h11);
    ck("R4", "single-slot irq_level", int'(irq_level), 1);
    ck("R1", "single-slot full", int'(full), 1);
    push_line(8'h22);
    ck("R1", "single-slot count", int'(count), 1);
    ck("R8", "overrun on drop", int'(overrun), 1);
    // R11 in single slot: push with pop
    line_valid = 1; line_data = 8'h33; pop = 1; cyc(); idle();
    ck("R11", "slot swap rd_data", int'(rd_data), 8'h11);
    ck("R11", "slot swap count", int'(count), 1);
    ovr_clr = 1; line_valid = 1; line_data = 8'h44; cyc(); idle();
    ck("R8", "drop beats clear", int'(overrun), 1);
    ovr_clr = 1; cyc(); idle();
    ck("R8", "overrun cleared", int'(overrun), 0);

    // R2 flush on mode change, arrival in that cycle discarded
    fifo_en = 1; line_valid = 1; line_data = 8'h55; cyc(); idle();
    ck("R2", "flush count", int'(count), 0);
    ck("R2", "flush irq_data", int'(irq_data), 0);
    ck("R2", "flush irq_level", int'(irq_level), 0);

    // R3/R5 each threshold code
    for (int sel = 0; sel < 8; sel++) begin
      lvl_sel = 3'(sel);
      rise = 0;
      for (int k = 1; k <= DEPTH; k++) begin
        push_line(k + sel * 16);
        if (irq_level && rise == 0) rise = k;
      end
      ck("R3", $sformatf("threshold code %0d", sel), rise, exp_thr(sel, 1));
      ck("R1", "buffered full count", int'(count), DEPTH);
      for (int k = 1; k <= DEPTH; k++) begin
        pop1();
        if (k == 1) ck("R13", "fifo order head", int'(rd_data), 1 + sel * 16);
      end
      ck("R6", "level cleared after drain", int'(irq_level), 0);
    end

    // R8 buffered overflow, R11 full push+pop
    lvl_sel = 3'd2;
    for (int k = 0; k < DEPTH; k++) push_line(8'hA0 + k);
    line_valid = 1; line_data = 8'h77; pop = 1; cyc(); idle();
    ck("R11", "full swap rd_data", int'(rd_data), 8'hA0);
    ck("R11", "full swap count", int'(count), DEPTH);
    ck("R11", "full swap no overrun", int'(overrun), 0);
    push_line(8'h78);
    ck("R8", "buffered overflow", int'(overrun), 1);
    ovr_clr = 1; cyc(); idle();

    // R6 threshold change alone does not move irq_level
    for (int k = 0; k < DEPTH - 10; k++) pop1();
    ck("R6", "above threshold", int'(irq_level), 1);
    lvl_sel = 3'd7; cyc();
    ck("R6", "sel change no effect", int'(irq_level), 1);
    pop1();
    ck("R6", "pop below new threshold", int'(irq_level), 0);

    // R2 flush with data, back to single slot
    set_mode(0);
    ck("R2", "flush with data count", int'(count), 0);
    ck("R2", "flush empty", int'(empty), 1);
    set_mode(1);

    // R12 pop on empty
    pop1();
    ck("R12", "empty pop rd_data", int'(rd_data), 0);
    ck("R12", "empty pop count", int'(count), 0);
    ck("R12", "empty pop irq", int'(irq_data), 0);

    // R10 source selection
    loop_en = 1;
    line_valid = 1; line_data = 8'hC1; tx_valid = 1; tx_data = 8'hD2; cyc(); idle();
    line_valid = 1; line_data = 8'hC3; cyc(); idle();
    ck("R10", "loop ignores line", int'(count), 1);
    loop_en = 0;
    tx_valid = 1; tx_data = 8'hD4; cyc(); idle();
    line_valid = 1; line_data = 8'hC5; cyc(); idle();
    ck("R10", "normal ignores tx", int'(count), 2);
    pop1();
    ck("R10", "loopback data", int'(rd_data), 8'hD2);
    pop1();
    ck("R10", "line data", int'(rd_data), 8'hC5);
    ck("R7", "data irq cleared", int'(irq_data), 0);

    repeat (3) cyc();
    finish_run();
  end
endmodule